// File: doc/BRIEF.md
# Seven-Bit Serial Character Transmitter

This block turns a 7-bit parallel character into an asynchronous serial frame on a single output line. The line rests at mark (logic 1). A frame opens with one start bit at space (logic 0) and carries the seven data bits lowest bit first. An odd parity bit follows the data, and the frame closes with one stop bit at mark. An internal divider turns the system clock into a bit-rate enable pulse. With a 100 MHz clock, the default divide ratio gives a rate of 300 bit/s. Every register runs on the one system clock, and the bit-rate pulse serves only as an enable.

A one-hot sequencer controls the rest of the block. It steps through five phases: idle, load, count, shift and wait. In the load phase it captures the character together with its parity bit into a shift register, clears a modulo-10 bit counter and restarts the rate divider. It then alternates between counting and shifting until ten bit times have gone out. After that it waits until the send request drops before it accepts a new character. The busy output comes straight from a flip-flop, so it cannot glitch.

Top module: `serial_char_tx`

## Requirements
- R1: After reset, and whenever busy is low, the line output is 1 (mark) and busy is 0.
- R2: The frame bit order is: start bit 0, then data bit 0 through data bit 6, then the parity bit, then stop bit 1.
- R3: The parity bit makes the number of ones across the seven data bits and the parity bit odd.
- R4: The start bit begins one clock after busy rises and lasts CLKS_PER_BIT+1 clocks. Every later bit lasts exactly CLKS_PER_BIT clocks. The line returns to mark 10*CLKS_PER_BIT+1 clocks after the start bit begins.
- R5: When send_req is sampled high while the block is idle, busy goes high on the next clock. Busy stays high for the whole frame.
- R6: After the stop bit, busy stays high and the line stays at mark for as long as send_req is held. Busy falls one clock after send_req is sampled low.
- R7: The character is captured at the start of a frame. A send_req pulse or a change of char_in while busy is high does not affect the frame and does not start another frame.
- R8: While the block is idle and send_req is low, changes on char_in leave the line at mark and busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| send_req | input | 1 | Request to send the character on char_in |
| char_in | input | 7 | Character to send |
| tx_line | output | 1 | Serial output line, registered |
| busy | output | 1 | High from load until the block returns to idle, registered |

## Verification
The bench samples every bit at its midpoint and checks the long start bit and the exact cycle at which the line returns to mark. This catches a design that loses a bit, sends ten data bits or shifts one bit time late. Characters with all zeros and with all ones drive parity to 1 and 0 respectively, which exposes an even-parity generator. Holding send_req past the frame tests that the block stays in wait instead of sending the character a second time. A send_req pulse with fresh data in the middle of a frame tests that the data is captured only at load and that a second frame does not start.

// File: rtl/sct_pkg.sv
package sct_pkg;

  typedef enum logic [4:0] {
    ST_IDLE  = 5'b00001,
    ST_LOAD  = 5'b00010,
    ST_COUNT = 5'b00100,
    ST_SHIFT = 5'b01000,
    ST_WAIT  = 5'b10000
  } sct_state_e;

endpackage

// File: rtl/sct_rate_gen.sv
module sct_rate_gen #(
  parameter int DIV = 333334
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  p_tick_gap_r4: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
  p_clear_restart_r4: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !tick_o);
endmodule

// File: rtl/sct_parity.sv
module sct_parity #(
  parameter int W = 7
) (
  input  logic [W-1:0] data_i,
  output logic         par_o
);
  assign par_o = ~(^data_i);

  always_comb begin
    if (!$isunknown(data_i))
      p_odd_total_r3: assert (($countones(data_i) + int'(par_o)) % 2 == 1);
  end
endmodule

// File: rtl/sct_shifter.sv
module sct_shifter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] frame_i,
  input  logic         shift_i,
  output logic         line_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '1;
    else if (load_i) sr_q <= frame_i;
    else if (shift_i) sr_q <= {1'b1, sr_q[W-1:1]};
  end

  assign line_o = sr_q[0];

  p_load_start_r2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (line_o == 1'b0));
endmodule

// File: rtl/sct_bit_counter.sv
module sct_bit_counter #(
  parameter int MOD = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = $clog2(MOD);
  localparam logic [CW-1:0] TOP = CW'(MOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == TOP);

  p_cnt_range_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= TOP);
endmodule

// File: rtl/sct_ctrl.sv
module sct_ctrl
  import sct_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic send_i,
  input  logic tick_i,
  input  logic last_i,
  output logic load_o,
  output logic shift_o,
  output logic busy_o
);
  sct_state_e state_q, state_n;
  logic       busy_q;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:  if (send_i) state_n = ST_LOAD;
      ST_LOAD:  state_n = ST_COUNT;
      ST_COUNT: if (tick_i) state_n = ST_SHIFT;
      ST_SHIFT: state_n = last_i ? ST_WAIT : ST_COUNT;
      ST_WAIT:  if (!send_i) state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      busy_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      busy_q  <= (state_n != ST_IDLE);
    end
  end

  assign load_o  = (state_q == ST_LOAD);
  assign shift_o = (state_q == ST_SHIFT);
  assign busy_o  = busy_q;

  p_state_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(state_q) == 1);
  p_busy_rise_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && send_i) |=> busy_o);
  p_wait_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && send_i) |=> (state_q == ST_WAIT && busy_o));
  p_wait_release_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && !send_i) |=> !busy_o);
endmodule

// File: rtl/serial_char_tx.sv
module serial_char_tx #(
  parameter int DATA_W       = 7,
  parameter int CLKS_PER_BIT = 333334
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              send_req,
  input  logic [DATA_W-1:0] char_in,
  output logic              tx_line,
  output logic              busy
);
  localparam int FRAME_W = DATA_W + 3;

  logic               tick, load, shift, last, par;
  logic [FRAME_W-1:0] frame;

  sct_rate_gen #(.DIV(CLKS_PER_BIT)) u_rate (
    .clk(clk), .rst(rst), .clr_i(load), .tick_o(tick));

  sct_parity #(.W(DATA_W)) u_par (
    .data_i(char_in), .par_o(par));

  assign frame = {1'b1, par, char_in, 1'b0};

  sct_shifter #(.W(FRAME_W)) u_sr (
    .clk(clk), .rst(rst), .load_i(load), .frame_i(frame),
    .shift_i(shift), .line_o(tx_line));

  sct_bit_counter #(.MOD(FRAME_W)) u_cnt (
    .clk(clk), .rst(rst), .clr_i(load), .inc_i(shift), .last_o(last));

  sct_ctrl u_ctrl (
    .clk(clk), .rst(rst), .send_i(send_req), .tick_i(tick),
    .last_i(last), .load_o(load), .shift_o(shift), .busy_o(busy));

  p_idle_mark_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx_line);
endmodule

// File: tb/test_serial_char_tx.sv
module test_serial_char_tx;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       send_req = 1'b0;
  logic [6:0] char_in = '0;
  logic       tx_line, busy;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  serial_char_tx #(.DATA_W(7), .CLKS_PER_BIT(N)) i_serial_char_tx (
    .clk(clk), .rst(rst), .send_req(send_req), .char_in(char_in),
    .tx_line(tx_line), .busy(busy));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_line == 1'b1, "R1 line after reset", tx_line, 1);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
  endtask

  task automatic t_idle_quiet();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      char_in = 7'(i * 13);
    end
    @(negedge clk);
    chk(tx_line == 1'b1, "R8 line idle", tx_line, 1);
    chk(busy == 1'b0, "R8 busy idle", busy, 0);
  endtask

  task automatic t_frame(input logic [6:0] d, input int hold, input bit poke);
    logic [9:0] exp;
    int cur;
    exp = {1'b1, ~(^d), d, 1'b0};
    @(negedge clk);
    send_req = 1'b1;
    char_in = d;
    @(negedge clk);
    chk(busy == 1'b1, "R5 busy rises", busy, 1);
    chk(tx_line == 1'b1, "R4 line mark in load cycle", tx_line, 1);
    if (hold == 0) send_req = 1'b0;
    @(negedge clk);
    cur = 0;
    chk(tx_line == 1'b0, "R4 start bit begins", tx_line, 0);
    for (int k = 0; k < 10; k++) begin
      int target = 1 + k * N + N / 2;
      repeat (target - cur) @(negedge clk);
      cur = target;
      if (poke && k == 3) begin
        send_req = 1'b1;
        char_in = ~d;
      end
      if (poke && k == 4) send_req = 1'b0;
      chk(tx_line == exp[k], $sformatf("R2 bit %0d of char %0h", k, d), tx_line, exp[k]);
      chk(busy == 1'b1, "R5 busy during frame", busy, 1);
      if (k == 8)
        chk((($countones(d) + int'(tx_line)) % 2) == 1, "R3 odd parity",
            $countones(d) + int'(tx_line), $countones(d) + int'(exp[8]));
    end
    repeat (10 * N - cur) @(negedge clk);
    chk(tx_line == 1'b1, "R4 stop bit end", tx_line, 1);
    @(negedge clk);
    chk(tx_line == 1'b1, "R4 mark after frame", tx_line, 1);
    chk(busy == 1'b1, "R6 busy in wait", busy, 1);
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      chk(busy == 1'b1, "R6 busy held with send", busy, 1);
      chk(tx_line == 1'b1, "R6 no resend while held", tx_line, 1);
      send_req = 1'b0;
      @(negedge clk);
      chk(busy == 1'b0, "R6 busy falls after release", busy, 0);
    end else begin
      @(negedge clk);
      chk(busy == 1'b0, "R6 busy falls", busy, 0);
    end
    if (poke) begin
      for (int i = 0; i < 3 * N; i++) begin
        @(negedge clk);
        chk(tx_line == 1'b1 && busy == 1'b0, "R7 no extra frame",
            {busy, tx_line}, 1);
      end
    end
  endtask

  initial begin
    t_reset();
    t_idle_quiet();
    t_frame(7'h57, 0, 1'b0);
    t_frame(7'h00, 0, 1'b0);
    t_frame(7'h7F, 0, 1'b0);
    t_frame(7'h01, 25, 1'b0);
    t_frame(7'h2A, 0, 1'b1);
    t_frame(7'h40, 0, 1'b0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule